// File: doc/BRIEF.md
# Windowed Max-Log Soft-In Soft-Out Decoder Step

This block is the soft-in soft-out engine for one constituent code of a turbo decoder. It works on a window of 1 to `MAXM` trellis steps of an 8-state recursive systematic convolutional code. The feedback polynomial is 13 (octal) and the feedforward polynomial is 15 (octal).

The host pulses `start` with a window length and a backward seed. It then streams one (systematic, parity, a-priori) triple per accepted cycle. During this load phase the block runs the forward state-metric recursion and stores the forward metrics of each step locally. When the window is complete, a backward recursion walks the window from the last step to the first. It starts from boundary metrics that were saved in the previous iteration. For each step it emits an extrinsic value that combines the forward, branch and backward metrics. At the end it hands back the backward metrics of the window's first step, so they can be stored for the next iteration.

All metrics are signed 8-bit values. Every max* operation is replaced by a plain max. State metrics are renormalized against state 0 on every step.

Top module: `siso_maxlog`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `out_valid` and `bnd_wr_en` are 0.
- R2: A `start` pulse while idle, with `win_len` in 1..MAXM, begins a job. A `start` while busy, or with `win_len` equal to 0 or above MAXM, is ignored and leaves the block idle or its job undisturbed.
- R3: State s = {s2,s1,s0}. For input bit u, the feedback bit is a = u^s1^s2, the parity is p = a^s0^s2 and the next state is {s1,s0,a}. The branch metric is (u ? sys+apr : 0) + (p ? par : 0), with LLRs positive for bit 1.
- R4: Forward metrics start at 0 for every state. Each accepted symbol updates them as the max over both incoming branches of old metric plus branch metric, then subtracts the new state-0 value and saturates to [-128,127]. Exactly `win_len` cycles with `in_valid` high are consumed, and cycles with `in_valid` low are skipped.
- R5: The backward seed is sampled at `start`. If `bnd_zero` is 1 it is all zero. Otherwise state s takes `bnd_seed[8s+7:8s]`.
- R6: The extrinsic value of step k is sat(max over u=1 branches − max over u=0 branches) of alpha_k(s) + (p ? par : 0) + beta_{k+1}(next). Beta_k is the max over u of branch metric plus beta_{k+1}(next), less its state-0 value, saturated.
- R7: After the last symbol is accepted, `win_len` outputs follow on consecutive cycles, with `out_idx` running from `win_len`−1 down to 0. The first output appears one cycle after the edge that accepts the last symbol.
- R8: `bnd_wr_en` pulses for exactly one cycle, together with the index-0 output. `bnd_wr_data` then carries beta_0, packed like the seed, with its state-0 field equal to 0.
- R9: `busy` is high from the edge that accepts `start` until the edge that produces the last output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a window job |
| win_len | input | $clog2(MAXM)+1 | Window length in trellis steps |
| bnd_zero | input | 1 | Use an all-zero backward seed (first iteration) |
| bnd_seed | input | 8*W | Stored boundary backward metrics, state s at bits [W*s +: W] |
| in_valid | input | 1 | Symbol triple present |
| in_sys | input | W | Systematic LLR |
| in_par | input | W | Parity LLR |
| in_apr | input | W | A-priori LLR |
| busy | output | 1 | Job in progress |
| out_valid | output | 1 | Extrinsic value present |
| out_idx | output | $clog2(MAXM) | Step index of the extrinsic value |
| out_ext | output | W | Extrinsic LLR |
| bnd_wr_en | output | 1 | Boundary metrics write strobe |
| bnd_wr_data | output | 8*W | Beta of step 0 for the next iteration |

## Verification
The bench runs every window length from 1 to the maximum, with the zero seed and with arbitrary seeds. A design that used the wrong seed, or sampled it at the wrong time, would give wrong extrinsic values on the late steps first. A window of length 1 and a window at maximum length probe the off-by-one limits of the load counter and the reverse read. Either error would shift `out_idx` or drop an output. Full-scale LLR patterns drive the forward and backward metrics and the extrinsic sums into saturation, where a design that wraps instead of clamping would flip signs. Bubbles in `in_valid`, a held `start` during the backward pass and illegal lengths expose a design that takes symbols, jobs or lengths it should reject.

// File: rtl/siso_maxlog.sv
module siso_maxlog #(
  parameter int W    = 8,
  parameter int MAXM = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(MAXM):0]     win_len,
  input  logic                      bnd_zero,
  input  logic [8*W-1:0]            bnd_seed,
  input  logic                      in_valid,
  input  logic signed [W-1:0]       in_sys,
  input  logic signed [W-1:0]       in_par,
  input  logic signed [W-1:0]       in_apr,
  output logic                      busy,
  output logic                      out_valid,
  output logic [$clog2(MAXM)-1:0]   out_idx,
  output logic signed [W-1:0]       out_ext,
  output logic                      bnd_wr_en,
  output logic [8*W-1:0]            bnd_wr_data
);
  localparam int NS = 8;
  localparam int LW = $clog2(MAXM);
  localparam int AW = W + 4;

  typedef logic signed [W-1:0]  met_t;
  typedef logic signed [AW-1:0] acc_t;
  typedef enum logic [1:0] {IDLE, FWD, BWD} st_t;

  localparam acc_t HI  = acc_t'((1 <<< (W-1)) - 1);
  localparam acc_t LO  = acc_t'(-(1 <<< (W-1)));
  localparam acc_t NEG = acc_t'(-(1 <<< (AW-1)));

  function automatic logic [2:0] nxt(logic [2:0] s, logic u);
    return {s[1], s[0], u ^ s[1] ^ s[2]};
  endfunction

  function automatic logic parb(logic [2:0] s, logic u);
    return (u ^ s[1] ^ s[2]) ^ s[0] ^ s[2];
  endfunction

  function automatic met_t sat(acc_t v);
    if (v > HI) return met_t'(HI);
    if (v < LO) return met_t'(LO);
    return met_t'(v);
  endfunction

  function automatic acc_t gam(logic u, logic p, met_t s, met_t a, met_t q);
    acc_t g;
    g = '0;
    if (u) g = acc_t'(s) + acc_t'(a);
    if (p) g = g + acc_t'(q);
    return g;
  endfunction

  st_t            st;
  logic [LW:0]    len;
  logic [LW-1:0]  cnt, idx;
  met_t           alpha [NS];
  met_t           beta  [NS];
  met_t           alpha_n [NS];
  met_t           beta_n  [NS];
  met_t           a_mem [MAXM][NS];
  met_t           s_mem [MAXM];
  met_t           p_mem [MAXM];
  met_t           l_mem [MAXM];
  met_t           cs, cp, ca, ext;
  logic [8*W-1:0] bpack;

  assign busy = (st != IDLE);
  assign cs = (st == BWD) ? s_mem[idx] : in_sys;
  assign cp = (st == BWD) ? p_mem[idx] : in_par;
  assign ca = (st == BWD) ? l_mem[idx] : in_apr;

  always_comb begin
    acc_t fm [NS];
    acc_t bm [NS];
    acc_t m1, m0, v;
    logic [2:0] ns;
    for (int t = 0; t < NS; t++) fm[t] = NEG;
    m1 = NEG;
    m0 = NEG;
    for (int s = 0; s < NS; s++) begin
      bm[s] = NEG;
      for (int u = 0; u < 2; u++) begin
        ns = nxt(3'(s), 1'(u));
        v = acc_t'(alpha[s]) + gam(1'(u), parb(3'(s), 1'(u)), cs, ca, cp);
        if (v > fm[ns]) fm[ns] = v;
        v = gam(1'(u), parb(3'(s), 1'(u)), cs, ca, cp) + acc_t'(beta[ns]);
        if (v > bm[s]) bm[s] = v;
        v = acc_t'(a_mem[idx][s]) + gam(1'b0, parb(3'(s), 1'(u)), cs, ca, cp)
            + acc_t'(beta[ns]);
        if (u == 1) begin
          if (v > m1) m1 = v;
        end else begin
          if (v > m0) m0 = v;
        end
      end
    end
    for (int t = 0; t < NS; t++) begin
      alpha_n[t] = sat(fm[t] - fm[0]);
      beta_n[t]  = sat(bm[t] - bm[0]);
      bpack[t*W +: W] = beta_n[t];
    end
    ext = sat(m1 - m0);
  end

  always_ff @(posedge clk) begin
    if (st == FWD && in_valid) begin
      for (int s = 0; s < NS; s++) a_mem[cnt][s] <= alpha[s];
      s_mem[cnt] <= in_sys;
      p_mem[cnt] <= in_par;
      l_mem[cnt] <= in_apr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      len         <= '0;
      cnt         <= '0;
      idx         <= '0;
      out_valid   <= 1'b0;
      out_idx     <= '0;
      out_ext     <= '0;
      bnd_wr_en   <= 1'b0;
      bnd_wr_data <= '0;
      for (int s = 0; s < NS; s++) begin
        alpha[s] <= '0;
        beta[s]  <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      bnd_wr_en <= 1'b0;
      case (st)
        IDLE: if (start && win_len != 0 && win_len <= (LW+1)'(MAXM)) begin
          st  <= FWD;
          len <= win_len;
          cnt <= '0;
          for (int s = 0; s < NS; s++) begin
            alpha[s] <= '0;
            beta[s]  <= bnd_zero ? met_t'(0) : met_t'(bnd_seed[s*W +: W]);
          end
        end
        FWD: if (in_valid) begin
          for (int s = 0; s < NS; s++) alpha[s] <= alpha_n[s];
          if ((LW+1)'(cnt) == len - 1'b1) begin
            st  <= BWD;
            idx <= cnt;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BWD: begin
          out_valid <= 1'b1;
          out_ext   <= ext;
          out_idx   <= idx;
          for (int s = 0; s < NS; s++) beta[s] <= beta_n[s];
          if (idx == 0) begin
            st          <= IDLE;
            bnd_wr_en   <= 1'b1;
            bnd_wr_data <= bpack;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module siso_maxlog_chk #(
  parameter int W    = 8,
  parameter int MAXM = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    out_valid,
  input logic [$clog2(MAXM)-1:0] out_idx,
  input logic                    bnd_wr_en,
  input logic [8*W-1:0]          bnd_wr_data
);
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9
  AST_OUT_IN_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy)); // R7
  AST_IDX_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) - 1'b1)); // R7
  AST_WR_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_wr_en |-> (out_valid && out_idx == 0)); // R8
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_wr_en |=> !bnd_wr_en); // R8
  AST_WR_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_wr_en |-> (bnd_wr_data[W-1:0] == '0)); // R8
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == 0) |-> !busy); // R9
endmodule

bind siso_maxlog siso_maxlog_chk #(.W(W), .MAXM(MAXM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .out_valid(out_valid), .out_idx(out_idx),
  .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data)
);

// File: tb/siso_maxlog_tb.sv
module siso_maxlog_tb;
  localparam int W = 8;
  localparam int MAXM = 16;
  localparam int LW = $clog2(MAXM);

  logic clk = 0, rst_n = 0, start = 0, bnd_zero = 1, in_valid = 0;
  logic [LW:0] win_len = '0;
  logic [8*W-1:0] bnd_seed = '0;
  logic signed [W-1:0] in_sys = 0, in_par = 0, in_apr = 0;
  logic busy, out_valid, bnd_wr_en;
  logic [LW-1:0] out_idx;
  logic signed [W-1:0] out_ext;
  logic [8*W-1:0] bnd_wr_data;

  siso_maxlog #(.W(W), .MAXM(MAXM)) u_dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int lcg = 12345;
  int sv[MAXM], pv[MAXM], av[MAXM], seed[8], exp_ext[MAXM], exp_bnd[8];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd8();
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 16) & 255) - 128;
  endfunction

  function automatic int nx(int s, int u);
    int a = u ^ ((s >> 1) & 1) ^ ((s >> 2) & 1);
    return ((s << 1) & 6) | a;
  endfunction

  function automatic int pb(int s, int u);
    int a = u ^ ((s >> 1) & 1) ^ ((s >> 2) & 1);
    return a ^ (s & 1) ^ ((s >> 2) & 1);
  endfunction

  function automatic int sat8(int v);
    return v > 127 ? 127 : (v < -128 ? -128 : v);
  endfunction

  function automatic int g(int k, int u, int p, bit full);
    return ((u != 0 && full) ? sv[k] + av[k] : 0) + (p != 0 ? pv[k] : 0);
  endfunction

  task automatic model(int len, bit zero);
    int al[MAXM+1][8];
    int b[8], m[8], nb[8];
    for (int s = 0; s < 8; s++) al[0][s] = 0;
    for (int k = 0; k < len; k++) begin
      for (int t = 0; t < 8; t++) m[t] = -100000;
      for (int s = 0; s < 8; s++)
        for (int u = 0; u < 2; u++) begin
          int v = al[k][s] + g(k, u, pb(s, u), 1);
          if (v > m[nx(s, u)]) m[nx(s, u)] = v;
        end
      for (int t = 0; t < 8; t++) al[k+1][t] = sat8(m[t] - m[0]);
    end
    for (int s = 0; s < 8; s++) b[s] = zero ? 0 : seed[s];
    for (int k = len - 1; k >= 0; k--) begin
      int m1 = -100000, m0 = -100000;
      for (int s = 0; s < 8; s++) begin
        nb[s] = -100000;
        for (int u = 0; u < 2; u++) begin
          int v = al[k][s] + g(k, u, pb(s, u), 0) + b[nx(s, u)];
          int w = g(k, u, pb(s, u), 1) + b[nx(s, u)];
          if (u == 1 && v > m1) m1 = v;
          if (u == 0 && v > m0) m0 = v;
          if (w > nb[s]) nb[s] = w;
        end
      end
      exp_ext[k] = sat8(m1 - m0);
      for (int s = 0; s < 8; s++) b[s] = sat8(nb[s] - nb[0]);
    end
    for (int s = 0; s < 8; s++) exp_bnd[s] = b[s];
  endtask

  // mode: 0 random, 1 full-scale extremes
  task automatic run_job(int len, bit zero, int mode, bit gaps, bit ign);
    int k, cyc;
    for (int i = 0; i < len; i++) begin
      if (mode == 1) begin
        sv[i] = (i % 2) ? 127 : -128;
        av[i] = (i % 3) ? 127 : -128;
        pv[i] = (i % 2) ? -128 : 127;
      end else begin
        sv[i] = rnd8(); pv[i] = rnd8(); av[i] = rnd8();
      end
    end
    for (int s = 0; s < 8; s++) seed[s] = rnd8();
    model(len, zero);
    start = 1; win_len = (LW+1)'(len); bnd_zero = zero;
    for (int s = 0; s < 8; s++) bnd_seed[s*W +: W] = W'(seed[s]);
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R9 busy after start", busy, 1);
    k = 0; cyc = 0;
    while (k < len) begin
      in_valid = !(gaps && (cyc % 3 == 1));
      in_sys = W'(sv[k]); in_par = W'(pv[k]); in_apr = W'(av[k]);
      if (!in_valid) begin in_sys = 55; in_par = -77; in_apr = 99; end
      @(negedge clk);
      chk(out_valid == 0, "R4 no output while loading", out_valid, 0);
      if (in_valid) k++;
      cyc++;
    end
    in_valid = 0;
    for (int j = 0; j < len; j++) begin
      start = ign; win_len = 3;
      @(negedge clk);
      chk(out_valid == 1, "R7 output valid", out_valid, 1);
      chk(int'(out_idx) == len - 1 - j, "R7 output index", out_idx, len - 1 - j);
      chk(int'(out_ext) == exp_ext[len-1-j], "R6 extrinsic value", out_ext, exp_ext[len-1-j]);
      chk(bnd_wr_en == (j == len - 1), "R8 write strobe timing", bnd_wr_en, j == len - 1);
      if (j == len - 1) begin
        chk(busy == 0, "R9 busy ends with last output", busy, 0);
        for (int s = 0; s < 8; s++)
          chk(int'($signed(bnd_wr_data[s*W +: W])) == exp_bnd[s], "R5 R8 boundary beta",
              $signed(bnd_wr_data[s*W +: W]), exp_bnd[s]);
      end
    end
    start = 0;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R2 held start during job ignored", busy, 0);
    chk(bnd_wr_en == 0, "R8 single strobe", bnd_wr_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && out_valid == 0 && bnd_wr_en == 0, "R1 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0 && bnd_wr_en == 0, "R1 after reset", busy, 0);
    start = 1; win_len = 0;
    @(negedge clk);
    chk(busy == 0, "R2 zero length ignored", busy, 0);
    win_len = (LW+1)'(MAXM + 1);
    @(negedge clk);
    chk(busy == 0, "R2 oversize length ignored", busy, 0);
    start = 0;
    @(negedge clk);
    run_job(1, 1, 0, 0, 0);        // R3 R6 shortest window
    run_job(1, 0, 0, 0, 0);        // R5 seeded shortest window
    run_job(2, 0, 0, 1, 0);        // R4 bubbles
    run_job(MAXM, 1, 1, 0, 0);     // R4 R6 saturation
    run_job(MAXM, 0, 1, 1, 1);     // R2 R5 saturation with seed
    for (int len = 1; len <= MAXM; len++) begin
      run_job(len, len % 2 == 0, 0, len % 4 == 3, len % 5 == 0);
      run_job(len, 0, 0, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule